// File: doc/BRIEF.md
# Trace Exception Sequencer with STOP Handling

This block decides, instruction by instruction, whether a trace exception must be requested, and captures the program counter and status register image that the exception frame builder will store. Ordinary instructions are traced on completion whenever the trace-enable bit of the status register is set. The frame then points at the instruction that follows.

The STOP instruction gets its own sequence. The core offers each STOP to the sequencer before executing it. If tracing is already on, the STOP is held back and a trace is requested with the frame PC at the STOP opcode. The STOP executes only when the handler returns. A STOP that executes, either at once or after that return, pulses a status-register load with its immediate operand. If the loaded value has the trace bit set, a second trace follows, using the address after the STOP and the new status value. Otherwise the sequencer reports that the core is stopped.

Exceptions are taken one at a time and are never stacked. Another exception taken for the same instruction therefore cancels the trace request for it. The trace vector number is reported as a fixed value beside the frame.

Top module: `trc_ctrl`

## Requirements
- R1: During and after a synchronous reset, `trc_req`, `sr_load` and `stopped` are 0. `trc_vector` always reads 9.
- R2: On a non-STOP `instr_done` with `sr_cur[15]` = 1, `trc_req` is 1 from the next cycle. In that cycle `frame_pc` equals that cycle's `pc_next` and `frame_sr` equals `sr_cur`.
- R3: A raised `trc_req` stays 1, with `frame_pc` and `frame_sr` unchanged, until a cycle with `trc_ack` = 1 clears it. `instr_done` is ignored while a request is pending, so no instruction produces a second request.
- R4: An `instr_done` with `sr_cur[15]` = 0 raises no request, whether or not it is a STOP.
- R5: When `exc_taken` = 1 arrives with `instr_done`, the trace for that instruction is suppressed. When `exc_taken` = 1 arrives while a request is pending, the request is dropped from the next cycle.
- R6: A STOP offered (`instr_done` and `instr_is_stop`) with `sr_cur[15]` = 1 raises `trc_req` with `frame_pc` = `pc_cur` (the STOP address) and `frame_sr` = `sr_cur`. No status load happens until `exc_return` follows the acknowledge, and completions in between are ignored.
- R7: When a STOP executes, `sr_load` is a one-cycle pulse with `sr_load_val` equal to the STOP immediate. For a STOP offered with trace off, the pulse comes in the cycle after the offer. For a STOP held back by a trace, it comes in the cycle after `exc_return`.
- R8: If bit 15 of the loaded immediate is 1, the cycle after the load pulse has `trc_req` = 1, `frame_pc` = the `pc_next` given with the STOP offer, `frame_sr` = the immediate, and `stopped` = 0.
- R9: If bit 15 of the loaded immediate is 0, `stopped` is 1 from the cycle after the load pulse. While stopped, `instr_done` raises no request. A `wake` pulse clears `stopped` the next cycle.
- R10: If `exc_taken` arrives while the pre-STOP trace is pending, the request drops, the STOP is abandoned, and a later `exc_return` causes no status load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Instruction completion, or STOP offer when `instr_is_stop` is set |
| instr_is_stop | input | 1 | The offered instruction is a STOP |
| stop_imm | input | SR_W | STOP immediate operand |
| sr_cur | input | SR_W | Current status register |
| pc_cur | input | ADDR_W | Address of the offered instruction |
| pc_next | input | ADDR_W | Address of the instruction after it |
| exc_taken | input | 1 | Another exception is being taken |
| trc_ack | input | 1 | Trace request accepted by the exception unit |
| exc_return | input | 1 | Return from exception handler |
| wake | input | 1 | Leave the stopped state |
| trc_req | output | 1 | Trace exception request |
| trc_vector | output | VEC_W | Trace vector number (9) |
| frame_pc | output | ADDR_W | PC to store in the exception frame |
| frame_sr | output | SR_W | SR to store in the exception frame |
| sr_load | output | 1 | Load strobe for the status register |
| sr_load_val | output | SR_W | Value to load into the status register |
| stopped | output | 1 | Core is in the stopped state |

## Verification
The hardest situation to reach is the second half of the traced STOP. The STOP must first be held back by a trace, then acknowledged, and then released by a handler return, with completions arriving during the wait that must be ignored. The bench walks that path directly, once with an immediate that re-enables tracing and once without. It also runs a variant where a competing exception cancels the held trace. A sweep over trace-on/off, STOP/non-STOP, immediate trace bit and competing exception checks the first two response cycles of every combination from a fresh reset.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_PRE_STOP  = 3'd1,
        ST_WAIT_RET  = 3'd2,
        ST_STOP_EXEC = 3'd3,
        ST_STOPPED   = 3'd4
    } trc_state_e;

    typedef enum logic [1:0] {
        CAP_NEXT = 2'd0,
        CAP_CUR  = 2'd1,
        CAP_STOP = 2'd2
    } cap_src_e;

    function automatic logic trace_on(input logic [31:0] sr, input int unsigned bitpos);
        return sr[bitpos];
    endfunction

endpackage

// File: rtl/trc_seq.sv
module trc_seq
    import trc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       instr_done,
    input  logic       instr_is_stop,
    input  logic       t_now,
    input  logic       t_imm,
    input  logic       exc_taken,
    input  logic       trc_ack,
    input  logic       exc_return,
    input  logic       wake,
    output trc_state_e state,
    output logic       req,
    output logic       cap_en,
    output cap_src_e   cap_sel,
    output logic       stop_latch
);

    trc_state_e st_n;
    logic       req_n;

    always_comb begin
        st_n       = state;
        req_n      = req;
        cap_en     = 1'b0;
        cap_sel    = CAP_NEXT;
        stop_latch = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (req) begin
                    if (exc_taken || trc_ack) req_n = 1'b0;
                end else if (instr_done && !exc_taken) begin
                    if (instr_is_stop) begin
                        stop_latch = 1'b1;
                        if (t_now) begin
                            cap_en  = 1'b1;
                            cap_sel = CAP_CUR;
                            req_n   = 1'b1;
                            st_n    = ST_PRE_STOP;
                        end else begin
                            st_n = ST_STOP_EXEC;
                        end
                    end else if (t_now) begin
                        cap_en  = 1'b1;
                        cap_sel = CAP_NEXT;
                        req_n   = 1'b1;
                    end
                end
            end
            ST_PRE_STOP: begin
                if (exc_taken) begin
                    req_n = 1'b0;
                    st_n  = ST_RUN;
                end else if (trc_ack) begin
                    req_n = 1'b0;
                    st_n  = ST_WAIT_RET;
                end
            end
            ST_WAIT_RET: begin
                if (exc_return) st_n = ST_STOP_EXEC;
            end
            ST_STOP_EXEC: begin
                if (t_imm) begin
                    cap_en  = 1'b1;
                    cap_sel = CAP_STOP;
                    req_n   = 1'b1;
                    st_n    = ST_RUN;
                end else begin
                    st_n = ST_STOPPED;
                end
            end
            ST_STOPPED: begin
                if (wake) st_n = ST_RUN;
            end
            default: st_n = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            req   <= 1'b0;
        end else begin
            state <= st_n;
            req   <= req_n;
        end
    end

endmodule

// File: rtl/trc_frame.sv
module trc_frame
    import trc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SR_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  cap_src_e          cap_sel,
    input  logic              stop_latch,
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic [ADDR_W-1:0] pc_next,
    input  logic [SR_W-1:0]   sr_cur,
    input  logic [SR_W-1:0]   stop_imm,
    output logic [ADDR_W-1:0] frame_pc,
    output logic [SR_W-1:0]   frame_sr,
    output logic [SR_W-1:0]   stop_imm_q
);

    logic [ADDR_W-1:0] stop_npc_q;
    logic [ADDR_W-1:0] pc_sel;
    logic [SR_W-1:0]   sr_sel;

    always_comb begin
        unique case (cap_sel)
            CAP_CUR: begin
                pc_sel = pc_cur;
                sr_sel = sr_cur;
            end
            CAP_STOP: begin
                pc_sel = stop_npc_q;
                sr_sel = stop_imm_q;
            end
            default: begin
                pc_sel = pc_next;
                sr_sel = sr_cur;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_pc   <= '0;
            frame_sr   <= '0;
            stop_npc_q <= '0;
            stop_imm_q <= '0;
        end else begin
            if (cap_en) begin
                frame_pc <= pc_sel;
                frame_sr <= sr_sel;
            end
            if (stop_latch) begin
                stop_npc_q <= pc_next;
                stop_imm_q <= stop_imm;
            end
        end
    end

endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl
    import trc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SR_W      = 16,
    parameter int T_BIT     = 15,
    parameter int VEC_W     = 8,
    parameter int TRACE_VEC = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_done,
    input  logic              instr_is_stop,
    input  logic [SR_W-1:0]   stop_imm,
    input  logic [SR_W-1:0]   sr_cur,
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic [ADDR_W-1:0] pc_next,
    input  logic              exc_taken,
    input  logic              trc_ack,
    input  logic              exc_return,
    input  logic              wake,
    output logic              trc_req,
    output logic [VEC_W-1:0]  trc_vector,
    output logic [ADDR_W-1:0] frame_pc,
    output logic [SR_W-1:0]   frame_sr,
    output logic              sr_load,
    output logic [SR_W-1:0]   sr_load_val,
    output logic              stopped
);

    localparam logic [VEC_W-1:0] VEC_CODE = VEC_W'(TRACE_VEC);

    trc_state_e      state;
    logic            cap_en;
    cap_src_e        cap_sel;
    logic            stop_latch;
    logic [SR_W-1:0] imm_q;
    logic            t_now;
    logic            t_imm;

    assign t_now = trace_on(32'(sr_cur), T_BIT);
    assign t_imm = trace_on(32'(imm_q), T_BIT);

    trc_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .instr_done   (instr_done),
        .instr_is_stop(instr_is_stop),
        .t_now        (t_now),
        .t_imm        (t_imm),
        .exc_taken    (exc_taken),
        .trc_ack      (trc_ack),
        .exc_return   (exc_return),
        .wake         (wake),
        .state        (state),
        .req          (trc_req),
        .cap_en       (cap_en),
        .cap_sel      (cap_sel),
        .stop_latch   (stop_latch)
    );

    trc_frame #(.ADDR_W(ADDR_W), .SR_W(SR_W)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_en),
        .cap_sel   (cap_sel),
        .stop_latch(stop_latch),
        .pc_cur    (pc_cur),
        .pc_next   (pc_next),
        .sr_cur    (sr_cur),
        .stop_imm  (stop_imm),
        .frame_pc  (frame_pc),
        .frame_sr  (frame_sr),
        .stop_imm_q(imm_q)
    );

    assign trc_vector  = VEC_CODE;
    assign sr_load     = (state == ST_STOP_EXEC);
    assign sr_load_val = imm_q;
    assign stopped     = (state == ST_STOPPED);

endmodule

// File: rtl/trc_ctrl_chk.sv
module trc_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int SR_W   = 16,
    parameter int T_BIT  = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              instr_done,
    input logic              exc_taken,
    input logic              trc_ack,
    input logic              trc_req,
    input logic [ADDR_W-1:0] frame_pc,
    input logic [SR_W-1:0]   frame_sr,
    input logic              sr_load,
    input logic [SR_W-1:0]   sr_load_val,
    input logic              stopped
);

    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        trc_req && !trc_ack && !exc_taken |=> trc_req && $stable(frame_pc) && $stable(frame_sr));

    p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
        trc_req && trc_ack |=> !trc_req);

    p_exc_drop_r5: assert property (@(posedge clk) disable iff (rst)
        instr_done && exc_taken && !sr_load |=> !trc_req);

    p_load_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        sr_load |=> !sr_load);

    p_stop_trace_r8: assert property (@(posedge clk) disable iff (rst)
        sr_load && sr_load_val[T_BIT] |=> trc_req && !stopped && frame_sr == $past(sr_load_val));

    p_stop_halt_r9: assert property (@(posedge clk) disable iff (rst)
        sr_load && !sr_load_val[T_BIT] |=> stopped && !trc_req);

    p_stopped_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        stopped |-> !trc_req && !sr_load);

endmodule

bind trc_ctrl trc_ctrl_chk #(.ADDR_W(ADDR_W), .SR_W(SR_W), .T_BIT(T_BIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .instr_done (instr_done),
    .exc_taken  (exc_taken),
    .trc_ack    (trc_ack),
    .trc_req    (trc_req),
    .frame_pc   (frame_pc),
    .frame_sr   (frame_sr),
    .sr_load    (sr_load),
    .sr_load_val(sr_load_val),
    .stopped    (stopped)
);

// File: tb/test_trc_ctrl.sv
`timescale 1ns/1ps
module test_trc_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_done, instr_is_stop, exc_taken, trc_ack, exc_return, wake;
    logic [15:0] stop_imm, sr_cur;
    logic [31:0] pc_cur, pc_next;
    logic        trc_req, sr_load, stopped;
    logic [7:0]  trc_vector;
    logic [31:0] frame_pc;
    logic [15:0] frame_sr, sr_load_val;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    trc_ctrl i_trc_ctrl (
        .clk(clk), .rst(rst), .instr_done(instr_done), .instr_is_stop(instr_is_stop),
        .stop_imm(stop_imm), .sr_cur(sr_cur), .pc_cur(pc_cur), .pc_next(pc_next),
        .exc_taken(exc_taken), .trc_ack(trc_ack), .exc_return(exc_return), .wake(wake),
        .trc_req(trc_req), .trc_vector(trc_vector), .frame_pc(frame_pc), .frame_sr(frame_sr),
        .sr_load(sr_load), .sr_load_val(sr_load_val), .stopped(stopped)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        instr_done = 0; instr_is_stop = 0; exc_taken = 0;
        trc_ack = 0; exc_return = 0; wake = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic offer(input logic stop, input logic [31:0] pc, input logic [15:0] sr,
                         input logic [15:0] imm);
        instr_done = 1; instr_is_stop = stop; pc_cur = pc; pc_next = pc + 4;
        sr_cur = sr; stop_imm = imm;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        sr_cur = 0; stop_imm = 0; pc_cur = 0; pc_next = 0;
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 req", trc_req, 0);
        chk("R1 load", sr_load, 0);
        chk("R1 stopped", stopped, 0);
        chk("R1 vector", trc_vector, 9);

        // Sweep: trace, stop, immediate trace bit, competing exception
        for (int c = 0; c < 16; c++) begin
            logic t, s, ti, ex;
            logic [31:0] pc;
            logic [15:0] sr, imm;
            t = c[0]; s = c[1]; ti = c[2]; ex = c[3];
            pc  = 32'h1000 + 32'(c) * 16;
            sr  = t ? 16'h8700 : 16'h0700;
            imm = ti ? 16'hA5A0 : 16'h2310;
            do_reset();
            exc_taken = ex;
            offer(s, pc, sr, imm);
            // first cycle after the offer
            if (ex) begin
                chk("R5 sweep req", trc_req, 0);
                chk("R5 sweep load", sr_load, 0);
            end else if (!t) begin
                chk("R4 sweep req", trc_req, 0);
                chk("R7 sweep load", sr_load, s);
                if (s) chk("R7 sweep val", sr_load_val, imm);
            end else begin
                chk("R2 R6 sweep req", trc_req, 1);
                chk("R2 R6 sweep pc", frame_pc, s ? pc : pc + 4);
                chk("R2 R6 sweep sr", frame_sr, sr);
                chk("R6 sweep load", sr_load, 0);
            end
            step();
            // second cycle
            if (ex || (!t && !s)) begin
                chk("R5 R4 sweep req2", trc_req, 0);
                chk("R5 R4 sweep stop2", stopped, 0);
            end else if (t) begin
                chk("R3 sweep hold", trc_req, 1);
                chk("R3 sweep hold pc", frame_pc, s ? pc : pc + 4);
                chk("R6 sweep no load", sr_load, 0);
            end else if (ti) begin
                chk("R8 sweep req", trc_req, 1);
                chk("R8 sweep pc", frame_pc, pc + 4);
                chk("R8 sweep sr", frame_sr, imm);
                chk("R8 sweep stopped", stopped, 0);
            end else begin
                chk("R9 sweep stopped", stopped, 1);
                chk("R9 sweep req", trc_req, 0);
            end
        end

        // R3: hold, ignore completion while pending, acknowledge
        do_reset();
        offer(0, 32'h40, 16'h8001, 16'h0);
        step(); step();
        chk("R3 hold req", trc_req, 1);
        chk("R3 hold pc", frame_pc, 32'h44);
        offer(0, 32'h80, 16'h8002, 16'h0);
        chk("R3 no second pc", frame_pc, 32'h44);
        chk("R3 no second sr", frame_sr, 16'h8001);
        trc_ack = 1; step();
        chk("R3 ack clears", trc_req, 0);
        step();
        chk("R3 stays clear", trc_req, 0);

        // R5: pending request dropped by another exception
        offer(0, 32'h50, 16'h8000, 16'h0);
        chk("R5 pending set", trc_req, 1);
        exc_taken = 1; step();
        chk("R5 pending dropped", trc_req, 0);

        // R6/R7/R9: traced STOP, return path, immediate without trace
        do_reset();
        offer(1, 32'h300, 16'h8000, 16'h2700);
        chk("R6 pc at stop", frame_pc, 32'h300);
        trc_ack = 1; step();
        chk("R6 acked", trc_req, 0);
        offer(0, 32'h900, 16'h8000, 16'h0);
        step();
        chk("R6 wait no req", trc_req, 0);
        chk("R6 wait no load", sr_load, 0);
        chk("R6 wait not stopped", stopped, 0);
        exc_return = 1; step();
        chk("R7 load after return", sr_load, 1);
        chk("R7 load value", sr_load_val, 16'h2700);
        step();
        chk("R9 stopped", stopped, 1);
        chk("R7 single pulse", sr_load, 0);
        offer(0, 32'h500, 16'h8000, 16'h0);
        chk("R9 ignored while stopped", trc_req, 0);
        wake = 1; step();
        chk("R9 wake", stopped, 0);
        offer(0, 32'h600, 16'h8000, 16'h0);
        chk("R9 running again", trc_req, 1);

        // R8: traced STOP whose immediate re-enables trace
        do_reset();
        offer(1, 32'h700, 16'h8000, 16'hA123);
        trc_ack = 1; step();
        exc_return = 1; step();
        chk("R7 load traced stop", sr_load, 1);
        step();
        chk("R8 req", trc_req, 1);
        chk("R8 pc after stop", frame_pc, 32'h704);
        chk("R8 sr new", frame_sr, 16'hA123);
        chk("R8 not stopped", stopped, 0);

        // R10: pre-STOP trace cancelled by another exception
        do_reset();
        offer(1, 32'h800, 16'h8000, 16'h2000);
        chk("R10 pending", trc_req, 1);
        exc_taken = 1; step();
        chk("R10 dropped", trc_req, 0);
        exc_return = 1; step();
        chk("R10 no load", sr_load, 0);
        step();
        chk("R10 not stopped", stopped, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule